// File: doc/BRIEF.md
# Offload Engine Control Sequencer

This block is the control master that brings a hardware TCP offload core into service and then drives its traffic. After a start pulse it loads the core's network settings through a 32-bit register write port, one register per cycle. It then takes the core out of reset and waits for the core's busy flag to fall, which marks the end of initialisation. After that it raises an init-done flag.

Once the core is ready, the sequencer waits for a connection. In send mode it programs a very large total length and a packet length, enables an external pattern generator, and issues a fixed number of bulk send commands. Each command is followed by a wait for the busy flag to fall. An active close then ends the session. In receive mode it issues nothing: it waits for the far end to close the connection and for the core to drain, then waits for the next connection.

The busy flag is bit 0 of the core's command register, and it is presented to this block as a single input. Register addresses and command codes are fixed locally and listed below.

Top module: `toe_seq_top`

## Requirements
- R1: After reset, `regWrEn`, `initDone` and `txEnable` are 0, and no register write is issued until `startIn` is seen high.
- R2: After start, eleven single-cycle writes are issued in this order (address: value): 0: 0x02030405 (MAC low word), 1: 0x00000001 (MAC high half), 2: 0xC0A80719 (target IP), 3: 0xC0A8072A (own IP), 4: 4001 (target port), 5: 4000 (own port), 6: 1456 (total length), 7: 312500000 (timeout), 8: 1456 (packet length), 9: 4 (push mode), 10: 16 (window gap).
- R3: The write that follows the eleventh setting writes 0 to the reset register at address 11.
- R4: `initDone` rises only after a falling edge of `coreBusy` that follows the reset write. A falling edge means the registered previous value is 1 and the present value is 0. Once high, `initDone` stays high until reset.
- R5: While waiting for a connection, no write is issued as long as `connOn` is 0. When `connOn` is 1, the sequencer takes the send path if `modeSend` is 1 and the receive path if it is 0.
- R6: On the send path, 0x0FFFFFF8 is written to address 6 and `txEnable` goes high. Then address 8 is written with 1456 when `pktSizeSel` is 0, or with 8960 when it is 1.
- R7: The send command (value 1 to command address 12) is written exactly LOOP_COUNT times (default 8). Each write after the first comes only after a `coreBusy` falling edge that follows the previous one.
- R8: After the last send completes, the active close command (value 2 to address 12) is written. `txEnable` stays high until the next `coreBusy` falling edge, then drops, and the sequencer returns to wait for a connection.
- R9: The receive path issues no writes. It waits for `connOn` to be 0. Only after that does it wait for `rxFifoEmpty` to be 1 and `coreBusy` to be 0 together, and only then does it return to wait for a connection.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| startIn | input | 1 | Start request while idle |
| modeSend | input | 1 | 1 selects the send path, 0 the receive path |
| pktSizeSel | input | 1 | 0 selects 1456-byte packets, 1 selects 8960-byte packets |
| connOn | input | 1 | Connection established flag from the core |
| rxFifoEmpty | input | 1 | Core receive buffer empty |
| coreBusy | input | 1 | Command register bit 0 (busy) read from the core |
| regWrEn | output | 1 | Single-cycle register write strobe |
| regAddr | output | 4 | Register write address |
| regWrData | output | 32 | Register write data |
| initDone | output | 1 | Core initialisation complete |
| txEnable | output | 1 | Enable for the transmit pattern generator |

## Verification
The receive path is where two exit conditions can arrive in the same cycle: the connection drop, and the drain condition (buffer empty with busy low). The bench holds the buffer non-empty and forces busy high after the drop. It also raises a new connection in send mode during that time, and judges at the write port that no send setup begins until both drain conditions hold. On the send path, the final busy fall both ends the close and drops the transmit enable in one cycle. The bench judges this by sampling `txEnable` when the close write appears and again after busy falls, then checking that the next session begins cleanly.

// File: rtl/toe_seq_pkg.sv
package toe_seq_pkg;

  localparam int ADDR_W     = 4;
  localparam int DATA_W     = 32;
  localparam int NUM_PARAMS = 11;

  // register map (local choice)
  localparam logic [ADDR_W-1:0] ADDR_TOTLEN = 4'd6;
  localparam logic [ADDR_W-1:0] ADDR_PKTLEN = 4'd8;
  localparam logic [ADDR_W-1:0] ADDR_RESET  = 4'd11;
  localparam logic [ADDR_W-1:0] ADDR_CMD    = 4'd12;

  localparam logic [DATA_W-1:0] CMD_SEND    = 32'd1;
  localparam logic [DATA_W-1:0] CMD_CLOSE   = 32'd2;
  localparam logic [DATA_W-1:0] BULK_LEN    = 32'h0FFF_FFF8;
  localparam logic [DATA_W-1:0] PKT_SMALL   = 32'd1456;
  localparam logic [DATA_W-1:0] PKT_JUMBO   = 32'd8960;

  typedef enum logic [3:0] {
    ST_IDLE, ST_SET_PARAM, ST_CLR_RST, ST_WT_INIT, ST_WT_OPEN,
    ST_SET_TOTLEN, ST_SET_PKTLEN, ST_SEND_CMD, ST_WT_SEND, ST_CHK_LOOP,
    ST_ACLOSE, ST_WT_CLOSE, ST_RX_WT_CLOSE, ST_RX_END
  } seqState_e;

  typedef enum logic [2:0] {
    SEL_PARAM, SEL_RESET, SEL_TOTLEN, SEL_PKTLEN, SEL_SEND, SEL_CLOSE
  } wrSel_e;

  typedef struct packed {
    logic   wrEn;
    wrSel_e wrSel;
    logic   clrIdx;
    logic   incIdx;
    logic   clrLoop;
    logic   incLoop;
    logic   setTx;
    logic   clrTx;
    logic   setInit;
  } seqCtl_t;

endpackage

// File: rtl/toe_seq_dp.sv
module toe_seq_dp
  import toe_seq_pkg::*;
#(
  parameter int LOOP_COUNT = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  seqCtl_t           ctl,
  input  logic              coreBusy,
  input  logic              pktSizeSel,
  output logic              busyFall,
  output logic              paramLast,
  output logic              loopDone,
  output logic              regWrEn,
  output logic [ADDR_W-1:0] regAddr,
  output logic [DATA_W-1:0] regWrData,
  output logic              initDone,
  output logic              txEnable
);

  localparam int IDX_W  = $clog2(NUM_PARAMS);
  localparam int LOOP_W = $clog2(LOOP_COUNT + 1);

  logic              busyQ;
  logic [IDX_W-1:0]  paramIdx;
  logic [LOOP_W-1:0] loopCnt;
  logic [ADDR_W-1:0] nxtAddr;
  logic [DATA_W-1:0] nxtData;

  function automatic logic [DATA_W-1:0] paramValue(input logic [IDX_W-1:0] idx);
    case (idx)
      IDX_W'(0):  paramValue = 32'h0203_0405;   // MAC low word
      IDX_W'(1):  paramValue = 32'h0000_0001;   // MAC high half
      IDX_W'(2):  paramValue = 32'hC0A8_0719;   // target IP
      IDX_W'(3):  paramValue = 32'hC0A8_072A;   // own IP
      IDX_W'(4):  paramValue = 32'd4001;        // target port
      IDX_W'(5):  paramValue = 32'd4000;        // own port
      IDX_W'(6):  paramValue = 32'd1456;        // total length
      IDX_W'(7):  paramValue = 32'd312500000;   // timeout
      IDX_W'(8):  paramValue = 32'd1456;        // packet length
      IDX_W'(9):  paramValue = 32'd4;           // push mode
      IDX_W'(10): paramValue = 32'd16;          // window gap
      default:    paramValue = '0;
    endcase
  endfunction

  assign busyFall  = busyQ & ~coreBusy;
  assign paramLast = (paramIdx == IDX_W'(NUM_PARAMS - 1));
  assign loopDone  = (loopCnt == LOOP_W'(LOOP_COUNT));

  always_comb begin
    nxtAddr = '0;
    nxtData = '0;
    case (ctl.wrSel)
      SEL_PARAM:  begin nxtAddr = ADDR_W'(paramIdx); nxtData = paramValue(paramIdx); end
      SEL_RESET:  begin nxtAddr = ADDR_RESET;  nxtData = '0; end
      SEL_TOTLEN: begin nxtAddr = ADDR_TOTLEN; nxtData = BULK_LEN; end
      SEL_PKTLEN: begin nxtAddr = ADDR_PKTLEN; nxtData = pktSizeSel ? PKT_JUMBO : PKT_SMALL; end
      SEL_SEND:   begin nxtAddr = ADDR_CMD;    nxtData = CMD_SEND; end
      SEL_CLOSE:  begin nxtAddr = ADDR_CMD;    nxtData = CMD_CLOSE; end
      default:    begin nxtAddr = '0; nxtData = '0; end
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busyQ     <= 1'b0;
      paramIdx  <= '0;
      loopCnt   <= '0;
      regWrEn   <= 1'b0;
      regAddr   <= '0;
      regWrData <= '0;
      initDone  <= 1'b0;
      txEnable  <= 1'b0;
    end else begin
      busyQ   <= coreBusy;
      regWrEn <= ctl.wrEn;
      if (ctl.wrEn) begin
        regAddr   <= nxtAddr;
        regWrData <= nxtData;
      end
      if (ctl.clrIdx)      paramIdx <= '0;
      else if (ctl.incIdx) paramIdx <= paramIdx + 1'b1;
      if (ctl.clrLoop)     loopCnt <= '0;
      else if (ctl.incLoop && !loopDone) loopCnt <= loopCnt + 1'b1;
      if (ctl.setInit)     initDone <= 1'b1;
      if (ctl.setTx)       txEnable <= 1'b1;
      else if (ctl.clrTx)  txEnable <= 1'b0;
    end
  end

  // R4: once initialised, the flag never drops
  assert_init_sticky_R4: assert property (@(posedge clk) disable iff (!rstN)
    initDone |=> initDone);

  // R4: the flag rises only behind a busy falling edge
  assert_init_after_fall_R4: assert property (@(posedge clk) disable iff (!rstN)
    $rose(initDone) |-> ($past(busyQ) && !$past(coreBusy)));

  // R7: the send loop counter never runs past its limit
  assert_loop_bound_R7: assert property (@(posedge clk) disable iff (!rstN)
    loopCnt <= LOOP_W'(LOOP_COUNT));

  // R2: the parameter index stays inside the table
  assert_idx_bound_R2: assert property (@(posedge clk) disable iff (!rstN)
    paramIdx < IDX_W'(NUM_PARAMS));

endmodule

// File: rtl/toe_seq_fsm.sv
module toe_seq_fsm
  import toe_seq_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    startIn,
  input  logic    modeSend,
  input  logic    connOn,
  input  logic    rxFifoEmpty,
  input  logic    coreBusy,
  input  logic    busyFall,
  input  logic    paramLast,
  input  logic    loopDone,
  output seqCtl_t ctl
);

  seqState_e state, stateNxt;

  always_comb begin
    stateNxt = state;
    ctl      = '0;
    ctl.wrSel = SEL_PARAM;
    case (state)
      ST_IDLE: if (startIn) begin
        ctl.clrIdx = 1'b1;
        stateNxt   = ST_SET_PARAM;
      end
      ST_SET_PARAM: begin
        ctl.wrEn   = 1'b1;
        ctl.wrSel  = SEL_PARAM;
        ctl.incIdx = !paramLast;
        if (paramLast) stateNxt = ST_CLR_RST;
      end
      ST_CLR_RST: begin
        ctl.wrEn  = 1'b1;
        ctl.wrSel = SEL_RESET;
        stateNxt  = ST_WT_INIT;
      end
      ST_WT_INIT: if (busyFall) begin
        ctl.setInit = 1'b1;
        stateNxt    = ST_WT_OPEN;
      end
      ST_WT_OPEN: if (connOn) stateNxt = modeSend ? ST_SET_TOTLEN : ST_RX_WT_CLOSE;
      ST_SET_TOTLEN: begin
        ctl.wrEn    = 1'b1;
        ctl.wrSel   = SEL_TOTLEN;
        ctl.setTx   = 1'b1;
        ctl.clrLoop = 1'b1;
        stateNxt    = ST_SET_PKTLEN;
      end
      ST_SET_PKTLEN: begin
        ctl.wrEn  = 1'b1;
        ctl.wrSel = SEL_PKTLEN;
        stateNxt  = ST_SEND_CMD;
      end
      ST_SEND_CMD: begin
        ctl.wrEn  = 1'b1;
        ctl.wrSel = SEL_SEND;
        stateNxt  = ST_WT_SEND;
      end
      ST_WT_SEND: if (busyFall) begin
        ctl.incLoop = 1'b1;
        stateNxt    = ST_CHK_LOOP;
      end
      ST_CHK_LOOP: stateNxt = loopDone ? ST_ACLOSE : ST_SEND_CMD;
      ST_ACLOSE: begin
        ctl.wrEn  = 1'b1;
        ctl.wrSel = SEL_CLOSE;
        stateNxt  = ST_WT_CLOSE;
      end
      ST_WT_CLOSE: if (busyFall) begin
        ctl.clrTx = 1'b1;
        stateNxt  = ST_WT_OPEN;
      end
      ST_RX_WT_CLOSE: if (!connOn) stateNxt = ST_RX_END;
      ST_RX_END: if (rxFifoEmpty && !coreBusy) stateNxt = ST_WT_OPEN;
      default: stateNxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNxt;
  end

  // R1: the setting writes begin only after a start request
  assert_start_needed_R1: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_SET_PARAM && $past(state) == ST_IDLE) |-> $past(startIn));

  // R8: the close is issued only once the loop count is complete
  assert_close_after_loop_R8: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_ACLOSE) |-> loopDone);

  // R9: leaving the drain wait needs an empty buffer and an idle core
  assert_rx_exit_R9: assert property (@(posedge clk) disable iff (!rstN)
    ($past(state) == ST_RX_END && state == ST_WT_OPEN) |->
      ($past(rxFifoEmpty) && !$past(coreBusy)));

  // R5: a connection with send mode selected starts the send setup next
  assert_branch_send_R5: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_WT_OPEN && connOn && modeSend) |=> (state == ST_SET_TOTLEN));

endmodule

// File: rtl/toe_seq_top.sv
module toe_seq_top
  import toe_seq_pkg::*;
#(
  parameter int LOOP_COUNT = 8
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        startIn,
  input  logic        modeSend,
  input  logic        pktSizeSel,
  input  logic        connOn,
  input  logic        rxFifoEmpty,
  input  logic        coreBusy,
  output logic        regWrEn,
  output logic [3:0]  regAddr,
  output logic [31:0] regWrData,
  output logic        initDone,
  output logic        txEnable
);

  seqCtl_t ctl;
  logic    busyFall;
  logic    paramLast;
  logic    loopDone;

  toe_seq_fsm u_fsm (
    .clk         (clk),
    .rstN        (rstN),
    .startIn     (startIn),
    .modeSend    (modeSend),
    .connOn      (connOn),
    .rxFifoEmpty (rxFifoEmpty),
    .coreBusy    (coreBusy),
    .busyFall    (busyFall),
    .paramLast   (paramLast),
    .loopDone    (loopDone),
    .ctl         (ctl)
  );

  toe_seq_dp #(.LOOP_COUNT(LOOP_COUNT)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .ctl        (ctl),
    .coreBusy   (coreBusy),
    .pktSizeSel (pktSizeSel),
    .busyFall   (busyFall),
    .paramLast  (paramLast),
    .loopDone   (loopDone),
    .regWrEn    (regWrEn),
    .regAddr    (regAddr),
    .regWrData  (regWrData),
    .initDone   (initDone),
    .txEnable   (txEnable)
  );

endmodule

// File: tb/toe_seq_top_tb_top.sv
`timescale 1ns/1ps
module toe_seq_top_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int BUSY_LEN   = 6;
  localparam int WATCHDOG   = 20000;
  localparam int NSEND      = 8;

  // expected setup writes: {address, data}
  localparam logic [35:0] INIT_TBL [12] = '{
    {4'd0,  32'h0203_0405}, {4'd1,  32'h0000_0001}, {4'd2,  32'hC0A8_0719},
    {4'd3,  32'hC0A8_072A}, {4'd4,  32'd4001},      {4'd5,  32'd4000},
    {4'd6,  32'd1456},      {4'd7,  32'd312500000}, {4'd8,  32'd1456},
    {4'd9,  32'd4},         {4'd10, 32'd16},        {4'd11, 32'd0}
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic startIn = 1'b0, modeSend = 1'b0, pktSizeSel = 1'b0;
  logic connOn = 1'b0, rxFifoEmpty = 1'b1, coreBusy = 1'b0;
  logic regWrEn, initDone, txEnable;
  logic [3:0]  regAddr;
  logic [31:0] regWrData;

  logic [3:0]  logA [64];
  logic [31:0] logD [64];
  int wrCount = 0;
  int busyCnt = 0;
  bit holdBusy = 1'b0;
  int cyc = 0;
  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  toe_seq_top dut_i (
    .clk(clk), .rstN(rstN), .startIn(startIn), .modeSend(modeSend),
    .pktSizeSel(pktSizeSel), .connOn(connOn), .rxFifoEmpty(rxFifoEmpty),
    .coreBusy(coreBusy), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .initDone(initDone), .txEnable(txEnable)
  );

  // write logger and simple core busy model
  always @(negedge clk) begin
    coreBusy = holdBusy || (busyCnt > 0);
    if (busyCnt > 0) busyCnt = busyCnt - 1;
    if (rstN && regWrEn) begin
      if (wrCount < 64) begin
        logA[wrCount] = regAddr;
        logD[wrCount] = regWrData;
      end
      wrCount = wrCount + 1;
      if (regAddr == 4'd12 || regAddr == 4'd11) busyCnt = BUSY_LEN;
    end
  end

  // watchdog
  always @(negedge clk) begin
    cyc = cyc + 1;
    if (cyc == WATCHDOG && !finished) begin
      errors = errors + 1;
      checks = checks + 1;
      $display("FAIL watchdog expired act=%0d exp<%0d", cyc, WATCHDOG);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks = checks + 1;
    if (!ok) begin
      errors = errors + 1;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      #1;
    end
  endtask

  task automatic waitWrites(input int n);
    for (int i = 0; i < 3000 && wrCount < n; i++) tick(1);
  endtask

  task automatic sendSession(input int base, input logic sel, input string tag);
    modeSend = 1'b1; pktSizeSel = sel; connOn = 1'b1;
    waitWrites(base + 3 + NSEND);
    chk(txEnable == 1'b1, {tag, " R6 tx enable during send"}, txEnable, 1);
    connOn = 1'b0;
    chk(logA[base] == 4'd6 && logD[base] == 32'h0FFF_FFF8, {tag, " R6 total length"},
        {logA[base], logD[base]}, {4'd6, 32'h0FFF_FFF8});
    chk(logA[base+1] == 4'd8 && logD[base+1] == (sel ? 32'd8960 : 32'd1456),
        {tag, " R6 packet length"}, logD[base+1], sel ? 32'd8960 : 32'd1456);
    begin
      int nSend = 0;
      for (int k = 0; k < NSEND; k++)
        if (logA[base+2+k] == 4'd12 && logD[base+2+k] == 32'd1) nSend++;
      chk(nSend == NSEND, {tag, " R7 send command count"}, nSend, NSEND);
    end
    chk(logA[base+2+NSEND] == 4'd12 && logD[base+2+NSEND] == 32'd2, {tag, " R8 active close"},
        logD[base+2+NSEND], 2);
    tick(BUSY_LEN + 6);
    chk(txEnable == 1'b0, {tag, " R8 tx enable drops after close"}, txEnable, 0);
    chk(wrCount == base + 3 + NSEND, {tag, " R8 no extra writes"}, wrCount, base + 3 + NSEND);
  endtask

  initial begin
    tick(3);
    chk(regWrEn == 0 && initDone == 0 && txEnable == 0, "R1 reset outputs",
        {regWrEn, initDone, txEnable}, 0);
    rstN = 1'b1;
    tick(10);
    chk(wrCount == 0, "R1 no writes before start", wrCount, 0);

    startIn = 1'b1; tick(1); startIn = 1'b0;
    waitWrites(12);
    // R2 R3: walk the setup table
    for (int i = 0; i < 12; i++)
      chk(logA[i] == INIT_TBL[i][35:32] && logD[i] == INIT_TBL[i][31:0],
          (i == 11) ? "R3 reset register write" : "R2 setting write",
          {logA[i], logD[i]}, INIT_TBL[i]);
    tick(2);
    chk(initDone == 1'b0, "R4 init done held while busy", initDone, 0);
    tick(BUSY_LEN + 4);
    chk(initDone == 1'b1, "R4 init done after busy fall", initDone, 1);

    tick(10);
    chk(wrCount == 12, "R5 idle while no connection", wrCount, 12);

    sendSession(12, 1'b0, "A");
    sendSession(23, 1'b1, "B");
    chk(initDone == 1'b1, "R4 init done sticky", initDone, 1);

    // receive path with drain conditions held off
    modeSend = 1'b0; rxFifoEmpty = 1'b0; connOn = 1'b1;
    tick(10);
    chk(wrCount == 34, "R9 receive issues no writes", wrCount, 34);
    connOn = 1'b0; holdBusy = 1'b1;
    tick(3);
    modeSend = 1'b1; connOn = 1'b1;
    tick(10);
    chk(wrCount == 34, "R9 blocked by non-empty buffer", wrCount, 34);
    rxFifoEmpty = 1'b1;
    tick(10);
    chk(wrCount == 34, "R9 blocked by busy", wrCount, 34);
    holdBusy = 1'b0;
    waitWrites(35);
    chk(logA[34] == 4'd6, "R9 R5 returns and takes send path", logA[34], 6);
    waitWrites(34 + 3 + NSEND);
    connOn = 1'b0;
    tick(BUSY_LEN + 6);
    chk(txEnable == 1'b0, "R8 final session closed", txEnable, 0);

    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule